// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside a program sequencer and runs counted loops without any branch or decrement instructions in the loop body. It keeps two loop contexts, loop 0 and loop 1. Each context has a 32-bit top address, a 32-bit bottom address and an iteration count, so one loop can cover the entire 4 GB address space. Loop 1 is meant to be the inner loop when the two are nested. Every cycle the block compares the presented fetch address with the bottom of each active loop. When a loop's last instruction is fetched and iterations remain, the block asks the sequencer, in that same cycle, to fetch next from the loop top. On the final pass it lets the fetch run on sequentially.

A loop is configured in one of two ways. A setup command loads all three fields of a chosen loop in one cycle, and its count comes from a pointer value or from half of that value. Alternatively, a register move port writes any single field. In that case top and bottom are written first, and a nonzero count write then arms the loop with them. A combinational read port returns any field. If the setup command is issued so that the loop top is the next sequential address, looping costs no cycles at all. Otherwise the only cost is one redirect when the loop is entered.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset all six fields read as zero, and no redirect is produced for any fetch address.
- R2: When wr_en is high, wr_data is written at the clock edge into the field selected by wr_sel. wr_sel bit 2 selects the loop, and bits 1:0 select the field: 0 = top, 1 = bottom, 2 = count, 3 = reserved. A write with field code 3 changes nothing. A read with field code 3 returns zero. rd_sel uses the same encoding and returns the field combinationally.
- R3: When setup_en is high, the loop named by setup_loop loads top, bottom and count at the clock edge. The count is setup_src if setup_half is 0, and setup_src shifted right by one if setup_half is 1.
- R4: When fetch_valid is high, fetch_addr equals the bottom of the owning loop, and that loop's count is greater than 1, redirect_valid is 1 and redirect_addr equals that loop's top in the same cycle. The count is one lower after the edge.
- R5: When the owning loop matches with a count of 1, redirect_valid stays 0 and the count becomes 0 after the edge.
- R6: A loop whose count is 0 never matches. It never causes a redirect, and its count stays 0 until it is written.
- R7: When both loops match the same fetch address, loop 1 owns the match. Loop 0's count is not changed in that cycle.
- R8: Address comparison and redirect use all 32 address bits, including addresses at the very top of the address space.
- R9: For one loop in one cycle, a setup command takes precedence over a register write, and a register write takes precedence over the loop-end decrement. The redirect output in that cycle still reflects the fields held before the edge.
- R10: While fetch_valid is 0, redirect_valid is 0 and no count changes because of a fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | fetch_addr holds a real fetch this cycle |
| fetch_addr | input | 32 | Address of the instruction being fetched |
| redirect_valid | output | 1 | Fetch next from redirect_addr instead of sequentially |
| redirect_addr | output | 32 | Loop top to fetch next |
| wr_en | input | 1 | Single-field register write |
| wr_sel | input | 3 | Field select: bit 2 loop, bits 1:0 field |
| wr_data | input | 32 | Data written to the selected field |
| setup_en | input | 1 | Load all three fields of one loop |
| setup_loop | input | 1 | Loop addressed by the setup command |
| setup_top | input | 32 | Top address for setup |
| setup_bottom | input | 32 | Bottom address for setup |
| setup_src | input | 32 | Pointer value that the count is taken from |
| setup_half | input | 1 | 1 = count is setup_src shifted right by one |
| rd_sel | input | 3 | Read field select, encoded like wr_sel |
| rd_data | output | 32 | Selected field, count zero-extended |

## Verification
Two functions can meet in one cycle. One is the loop-end decrement of a loop whose bottom is being fetched. The other is a reconfiguration of that same loop, through either the move port or the setup command. The bench provokes this with directed cycles that fetch an active bottom while writing that loop's count, or while issuing a setup and a write together. Random traffic also aims fetches at the bottoms while writes and setups fire. In each such cycle the bench checks that redirect_valid follows the fields held before the edge, and that the stored result follows the setup-over-write-over-decrement order when read back on the next cycle. The priority of loop 1 over loop 0 on a shared bottom is judged the same way, by reading loop 0's count after a shared match.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

  typedef enum logic [1:0] {
    FLD_TOP = 2'd0,
    FLD_BOT = 2'd1,
    FLD_CNT = 2'd2,
    FLD_RSV = 2'd3
  } fld_e;

  // loop index carried in bit 2 of a field selector
  function automatic logic sel_loop(input logic [2:0] sel);
    return sel[2];
  endfunction

  function automatic fld_e sel_fld(input logic [2:0] sel);
    return fld_e'(sel[1:0]);
  endfunction

endpackage

// File: rtl/hwloop_ctx.sv
module hwloop_ctx
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              setup_hit,
  input  logic [ADDR_W-1:0] setup_top,
  input  logic [ADDR_W-1:0] setup_bottom,
  input  logic [CNT_W-1:0]  setup_cnt,
  input  logic              wr_hit,
  input  fld_e              wr_fld,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              claim,
  output logic [ADDR_W-1:0] top_o,
  output logic [ADDR_W-1:0] bottom_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              match_o,
  output logic              again_o
);

  logic [ADDR_W-1:0] top_q, bot_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [CNT_W-1:0] dec_count(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] move_count(input logic [ADDR_W-1:0] d);
    return d[CNT_W-1:0];
  endfunction

  // setup > register write > loop-end decrement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      bot_q <= '0;
      cnt_q <= '0;
    end else if (setup_hit) begin
      top_q <= setup_top;
      bot_q <= setup_bottom;
      cnt_q <= setup_cnt;
    end else if (wr_hit) begin
      unique case (wr_fld)
        FLD_TOP: top_q <= wr_data;
        FLD_BOT: bot_q <= wr_data;
        FLD_CNT: cnt_q <= move_count(wr_data);
        default: ;
      endcase
    end else if (claim) begin
      cnt_q <= dec_count(cnt_q);
    end
  end

  assign match_o  = (cnt_q != '0) && (fetch_addr == bot_q);
  assign again_o  = (cnt_q > CNT_W'(1));
  assign top_o    = top_q;
  assign bottom_o = bot_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/hwloop_arb.sv
module hwloop_arb #(
  parameter int ADDR_W = 32
) (
  input  logic              fetch_valid,
  input  logic [1:0]        match,
  input  logic [1:0]        again,
  input  logic [ADDR_W-1:0] top0,
  input  logic [ADDR_W-1:0] top1,
  output logic [1:0]        claim,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr
);

  // inner loop (1) owns a shared bottom
  always_comb begin
    claim          = 2'b00;
    redirect_valid = 1'b0;
    redirect_addr  = '0;
    if (fetch_valid) begin
      if (match[1]) begin
        claim[1] = 1'b1;
        if (again[1]) begin
          redirect_valid = 1'b1;
          redirect_addr  = top1;
        end
      end else if (match[0]) begin
        claim[0] = 1'b1;
        if (again[0]) begin
          redirect_valid = 1'b1;
          redirect_addr  = top0;
        end
      end
    end
  end

endmodule

// File: rtl/hwloop_rdmux.sv
module hwloop_rdmux
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic [2:0]                   rd_sel,
  input  logic [1:0][ADDR_W-1:0]       tops,
  input  logic [1:0][ADDR_W-1:0]       bots,
  input  logic [1:0][CNT_W-1:0]        cnts,
  output logic [ADDR_W-1:0]            rd_data
);

  function automatic logic [ADDR_W-1:0] widen(input logic [CNT_W-1:0] c);
    logic [ADDR_W-1:0] r;
    r = '0;
    r[CNT_W-1:0] = c;
    return r;
  endfunction

  logic l;
  assign l = sel_loop(rd_sel);

  always_comb begin
    unique case (sel_fld(rd_sel))
      FLD_TOP: rd_data = tops[l];
      FLD_BOT: rd_data = bots[l];
      FLD_CNT: rd_data = widen(cnts[l]);
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              setup_en,
  input  logic              setup_loop,
  input  logic [ADDR_W-1:0] setup_top,
  input  logic [ADDR_W-1:0] setup_bottom,
  input  logic [ADDR_W-1:0] setup_src,
  input  logic              setup_half,
  input  logic [2:0]        rd_sel,
  output logic [ADDR_W-1:0] rd_data
);

  localparam int NLOOP = 2;

  function automatic logic [CNT_W-1:0] load_count(input logic [ADDR_W-1:0] src,
                                                  input logic half);
    logic [ADDR_W-1:0] v;
    v = half ? (src >> 1) : src;
    return v[CNT_W-1:0];
  endfunction

  // named internal events
  logic [NLOOP-1:0]             setup_hit_w, wr_hit_w, upd_w;
  logic [NLOOP-1:0]             match_w, again_w, claim_w;
  logic [NLOOP-1:0][ADDR_W-1:0] top_w, bot_w;
  logic [NLOOP-1:0][CNT_W-1:0]  cnt_w;
  logic [CNT_W-1:0]             setup_cnt_w;
  fld_e                         wr_fld_w;

  assign setup_cnt_w = load_count(setup_src, setup_half);
  assign wr_fld_w    = sel_fld(wr_sel);

  for (genvar l = 0; l < NLOOP; l++) begin : g_loop
    assign setup_hit_w[l] = setup_en && (setup_loop == 1'(l));
    assign wr_hit_w[l]    = wr_en && (sel_loop(wr_sel) == 1'(l)) && (wr_fld_w != FLD_RSV);
    assign upd_w[l]       = setup_hit_w[l] || wr_hit_w[l];

    hwloop_ctx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctx (
      .clk          (clk),
      .rst_n        (rst_n),
      .fetch_addr   (fetch_addr),
      .setup_hit    (setup_hit_w[l]),
      .setup_top    (setup_top),
      .setup_bottom (setup_bottom),
      .setup_cnt    (setup_cnt_w),
      .wr_hit       (wr_hit_w[l]),
      .wr_fld       (wr_fld_w),
      .wr_data      (wr_data),
      .claim        (claim_w[l]),
      .top_o        (top_w[l]),
      .bottom_o     (bot_w[l]),
      .cnt_o        (cnt_w[l]),
      .match_o      (match_w[l]),
      .again_o      (again_w[l])
    );
  end

  hwloop_arb #(.ADDR_W(ADDR_W)) u_arb (
    .fetch_valid    (fetch_valid),
    .match          (match_w),
    .again          (again_w),
    .top0           (top_w[0]),
    .top1           (top_w[1]),
    .claim          (claim_w),
    .redirect_valid (redirect_valid),
    .redirect_addr  (redirect_addr)
  );

  hwloop_rdmux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd (
    .rd_sel  (rd_sel),
    .tops    (top_w),
    .bots    (bot_w),
    .cnts    (cnt_w),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/hwloop_chk.sv
module hwloop_chk #(
  parameter int CNT_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fetch_valid,
  input logic                 redirect_valid,
  input logic [1:0]           match,
  input logic [1:0]           claim,
  input logic [1:0]           upd,
  input logic [1:0][CNT_W-1:0] cnt
);

  // R10
  fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> fetch_valid);

  // R4
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim));

  // R4
  dec_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim[1] && !upd[1]) |=> (cnt[1] == $past(cnt[1]) - CNT_W'(1)));

  // R5
  last_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim[0] && cnt[0] == CNT_W'(1)) |-> !redirect_valid);

  // R6
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] == '0 && !upd[0]) |=> (cnt[0] == '0));

  // R7
  inner_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && match[0] && match[1] && !upd[0]) |=> $stable(cnt[0]));

endmodule

bind hwloop_ctrl hwloop_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fetch_valid    (fetch_valid),
  .redirect_valid (redirect_valid),
  .match          (match_w),
  .claim          (claim_w),
  .upd            (upd_w),
  .cnt            (cnt_w)
);

// File: tb/sim_hwloop_ctrl.sv
`timescale 1ns/1ps
module sim_hwloop_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        redirect_valid;
  logic [31:0] redirect_addr;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        setup_en = 1'b0;
  logic        setup_loop = 1'b0;
  logic [31:0] setup_top = '0, setup_bottom = '0, setup_src = '0;
  logic        setup_half = 1'b0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] mt [2];
  logic [31:0] mb [2];
  logic [31:0] mc [2];

  always #2.5 clk = ~clk;

  hwloop_ctrl u0 (.*);

  function automatic logic m_match(input int l);
    return (mc[l] != 0) && (fetch_addr == mb[l]);
  endfunction

  function automatic int m_owner();
    if (!fetch_valid) return -1;
    if (m_match(1)) return 1;
    if (m_match(0)) return 0;
    return -1;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] s);
    case (s[1:0])
      2'd0: return mt[s[2]];
      2'd1: return mb[s[2]];
      2'd2: return mc[s[2]];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs are already driven; check before the edge, then advance the model
  task automatic cycle(input string req);
    int  o;
    logic      ev;
    logic [31:0] ea;
    #1;
    o  = m_owner();
    ev = (o >= 0) && (mc[o] > 1);
    ea = ev ? mt[o] : 32'd0;
    check({req, " redirect_valid"}, {31'd0, redirect_valid}, {31'd0, ev});
    check({req, " redirect_addr"}, redirect_addr, ea);
    check({req, " rd_data"}, rd_data, m_read(rd_sel));
    @(posedge clk);
    for (int l = 0; l < 2; l++) begin
      if (setup_en && setup_loop == 1'(l)) begin
        mt[l] = setup_top;
        mb[l] = setup_bottom;
        mc[l] = setup_half ? (setup_src >> 1) : setup_src;
      end else if (wr_en && wr_sel[2] == 1'(l) && wr_sel[1:0] != 2'd3) begin
        case (wr_sel[1:0])
          2'd0: mt[l] = wr_data;
          2'd1: mb[l] = wr_data;
          default: mc[l] = wr_data;
        endcase
      end else if (o == l) begin
        mc[l] = mc[l] - 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    fetch_valid = 0; wr_en = 0; setup_en = 0;
  endtask

  task automatic do_setup(input logic l, input logic [31:0] t, input logic [31:0] b,
                          input logic [31:0] s, input logic h, input string req);
    idle();
    setup_en = 1; setup_loop = l; setup_top = t; setup_bottom = b;
    setup_src = s; setup_half = h;
    cycle(req);
    setup_en = 0;
  endtask

  task automatic do_write(input logic [2:0] s, input logic [31:0] d, input string req);
    idle();
    wr_en = 1; wr_sel = s; wr_data = d;
    cycle(req);
    wr_en = 0;
  endtask

  task automatic do_fetch(input logic [31:0] a, input logic [2:0] rs, input string req);
    idle();
    fetch_valid = 1; fetch_addr = a; rd_sel = rs;
    cycle(req);
    fetch_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int l = 0; l < 2; l++) begin mt[l] = 0; mb[l] = 0; mc[l] = 0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state, address 0 equals reset bottoms but count 0
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      fetch_valid = 1; fetch_addr = 0;
      cycle("R1");
    end

    // R2: single-field writes and reserved field
    do_write(3'd0, 32'h0000_0400, "R2");
    do_write(3'd1, 32'h0000_0420, "R2");
    do_write(3'd6, 32'd5, "R2");
    do_write(3'd3, 32'hDEAD_BEEF, "R2");
    do_write(3'd7, 32'hDEAD_BEEF, "R2");
    for (int s = 0; s < 8; s++) begin rd_sel = 3'(s); idle(); cycle("R2"); end
    do_write(3'd6, 32'd0, "R2");

    // R3: setup with halved count, then R4/R5/R6 loop run
    do_setup(1'b0, 32'h0000_0100, 32'h0000_0110, 32'd6, 1'b1, "R3");
    rd_sel = 3'd2; idle(); cycle("R3");
    do_fetch(32'h0000_0110, 3'd2, "R4");
    do_fetch(32'h0000_0110, 3'd2, "R4");
    do_fetch(32'h0000_0110, 3'd2, "R5");
    do_fetch(32'h0000_0110, 3'd2, "R6");
    do_setup(1'b0, 32'h0000_0100, 32'h0000_0110, 32'd7, 1'b0, "R3");
    rd_sel = 3'd2; idle(); cycle("R3");

    // R7: shared bottom, inner wins
    do_setup(1'b0, 32'h0000_0100, 32'h0000_0110, 32'd2, 1'b0, "R7");
    do_setup(1'b1, 32'h0000_0104, 32'h0000_0110, 32'd2, 1'b0, "R7");
    do_fetch(32'h0000_0110, 3'd2, "R7");
    do_fetch(32'h0000_0110, 3'd2, "R7");
    do_fetch(32'h0000_0110, 3'd2, "R7");
    rd_sel = 3'd6; idle(); cycle("R7");

    // R8: top of address space
    do_setup(1'b1, 32'hFFFF_FFF0, 32'hFFFF_FFFC, 32'd3, 1'b0, "R8");
    do_fetch(32'hFFFF_FFFC, 3'd6, "R8");
    do_fetch(32'h7FFF_FFFC, 3'd6, "R8");
    do_fetch(32'hFFFF_FFFC, 3'd6, "R8");

    // R10: fetch_valid low at bottom
    do_setup(1'b0, 32'h0000_0200, 32'h0000_0208, 32'd4, 1'b0, "R10");
    idle(); fetch_addr = 32'h0000_0208; rd_sel = 3'd2; cycle("R10");
    rd_sel = 3'd2; cycle("R10");

    // R9: write collides with decrement; setup collides with write
    idle(); fetch_valid = 1; fetch_addr = 32'h0000_0208;
    wr_en = 1; wr_sel = 3'd2; wr_data = 32'd9; rd_sel = 3'd2;
    cycle("R9");
    idle(); rd_sel = 3'd2; cycle("R9");
    idle(); fetch_valid = 1; fetch_addr = 32'h0000_0208;
    wr_en = 1; wr_sel = 3'd2; wr_data = 32'd1;
    setup_en = 1; setup_loop = 0; setup_top = 32'h300; setup_bottom = 32'h308;
    setup_src = 32'd10; setup_half = 1;
    cycle("R9");
    idle(); rd_sel = 3'd2; cycle("R9");
    rd_sel = 3'd0; cycle("R9");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int p;
      idle();
      fetch_valid = ($urandom_range(0, 9) < 8);
      p = $urandom_range(0, 4);
      case (p)
        0: fetch_addr = mb[0];
        1: fetch_addr = mb[1];
        2: fetch_addr = mt[$urandom_range(0, 1)];
        default: fetch_addr = 32'h200 + 4 * $urandom_range(0, 3);
      endcase
      if ($urandom_range(0, 19) == 0) begin
        setup_en = 1; setup_loop = 1'($urandom_range(0, 1));
        setup_top = 32'h180 + 4 * $urandom_range(0, 7);
        setup_bottom = 32'h200 + 4 * $urandom_range(0, 3);
        setup_src = $urandom_range(0, 12); setup_half = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 11) == 0) begin
        wr_en = 1; wr_sel = 3'($urandom_range(0, 7));
        wr_data = (wr_sel[1:0] == 2'd2) ? $urandom_range(0, 6)
                                        : 32'h200 + 4 * $urandom_range(0, 3);
      end
      rd_sel = 3'($urandom_range(0, 7));
      cycle("R9");
    end

    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule